// File: doc/BRIEF.md
# March C Memory Self-Test Engine with Live Fail Output

This block is a hardwired self-test engine for one embedded single-port memory with a 16-bit data word. A pulse on `start` makes it run a March C sequence over the whole address space. It issues exactly one memory operation per cycle and generates every address and every data word itself. The data backgrounds form a checkerboard, so every cell holds the complement of the cells around it whichever way the array is laid out.

The memory is expected to return read data one cycle after a read is issued. In that cycle the engine compares the word against the value the current element and read slot call for. It raises `rd_valid` and presents the OR of all bit mismatches on `rd_fail`, together with the address that was read. An external capture can therefore build a failure bitmap live during a single run. The same bit sets a sticky status that persists after the run, and a one-cycle `done` pulse marks the end of the run.

Top module: `march_c_bist`

## Requirements
- R1: A `start` accepted while idle runs six elements, one memory operation per cycle and 10·2^ADDR_W operation cycles in total. The elements are: ascending write "0"; ascending read "0" then write "1" per address; ascending read "1" then write "0"; descending read "0" then write "1"; descending read "1" then write "0"; ascending read "0".
- R2: The "0" background is 0x5555 at even addresses and 0xAAAA at odd addresses, so data bit i is 1 exactly when i plus the address is even. The "1" background is the bitwise inverse of the "0" background. Every written word comes from this rule.
- R3: `mem_we` and `mem_re` are never high in the same cycle.
- R4: The cycle after a read is issued, `rd_valid` is 1. In that cycle `rd_fail` is the OR over all bits of `mem_rdata` XOR the expected background, and `fail_addr` is the address of that read. In every other cycle `rd_valid` and `rd_fail` are 0.
- R5: `fail_sticky` goes to 1 the cycle after any `rd_fail` and stays at 1 until a start is accepted, which clears it.
- R6: `done` is high for exactly one cycle, two cycles after the final read is issued. No memory operation is issued in that cycle.
- R7: A `start` that arrives while a run is in progress, or while the final read check is still pending, is ignored: the sequence and the sticky status are unaffected.
- R8: A `start` presented in the `done` cycle is accepted. The sticky status clears and the first write, to address 0, is issued in the next cycle.
- R9: After reset, no memory operation is issued and `done`, `rd_valid` and `fail_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (accepted only when idle) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_re` |
| rd_valid | output | 1 | A read result is being checked this cycle |
| rd_fail | output | 1 | Combined mismatch of the read being checked |
| fail_addr | output | ADDR_W | Address of the read being checked |
| fail_sticky | output | 1 | Any mismatch seen since the last accepted start |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
In the two-operation elements, the check of a read's data falls in the same cycle as the write to that same address, issued from the second slot. A stuck bit is injected into the memory model at one address so that `rd_fail` and `fail_addr` must report the read while `mem_wdata` carries the new background. The bench judges both against its own reference operation list, and a stuck-at-1 and a stuck-at-0 fault must give three and two failures respectively. The end of one run can also meet the start of the next: `start` is driven in the `done` cycle. The bench then expects the sticky status to clear and a write to address 0 to follow at once.

// File: rtl/march_c_bist.sv
module march_c_bist #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic              rd_fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              fail_sticky,
  output logic              done
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [DATA_W-1:0] BG_EVEN  = {(DATA_W/2){2'b01}};
  localparam logic [2:0]        E_LAST   = 3'd5;

  logic              running, slot, rd_pend, last_q, done_q, sticky_q;
  logic [2:0]        elem;
  logic [ADDR_W-1:0] addr, raddr_q;
  logic [DATA_W-1:0] exp_q;

  logic              two_op, desc, pol_r, pol_w, is_read, is_write;
  logic              addr_end, step_addr, idle, accept;
  logic [DATA_W-1:0] bg;

  assign two_op   = (elem >= 3'd1) && (elem <= 3'd4);
  assign desc     = (elem == 3'd3) || (elem == 3'd4);
  assign pol_r    = (elem == 3'd2) || (elem == 3'd4);
  assign pol_w    = (elem == 3'd1) || (elem == 3'd3);
  assign is_read  = running && ((two_op && !slot) || elem == E_LAST);
  assign is_write = running && ((two_op && slot) || elem == 3'd0);
  assign addr_end = desc ? (addr == '0) : (addr == ADDR_MAX);
  assign step_addr = !two_op || slot;
  assign bg       = BG_EVEN ^ {DATA_W{addr[0]}};
  assign idle     = !running && !rd_pend;
  assign accept   = start && idle;

  assign mem_addr  = addr;
  assign mem_wdata = bg ^ {DATA_W{pol_w}};
  assign mem_we    = is_write;
  assign mem_re    = is_read;

  assign rd_valid    = rd_pend;
  assign rd_fail     = rd_pend && (|(mem_rdata ^ exp_q));
  assign fail_addr   = raddr_q;
  assign fail_sticky = sticky_q;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      elem    <= '0;
      slot    <= 1'b0;
      addr    <= '0;
    end else if (accept) begin
      running <= 1'b1;
      elem    <= '0;
      slot    <= 1'b0;
      addr    <= '0;
    end else if (running) begin
      if (!step_addr) begin
        slot <= 1'b1;
      end else begin
        slot <= 1'b0;
        if (!addr_end) begin
          addr <= desc ? addr - 1'b1 : addr + 1'b1;
        end else if (elem == E_LAST) begin
          running <= 1'b0;
        end else begin
          elem <= elem + 3'd1;
          addr <= (elem == 3'd2 || elem == 3'd3) ? ADDR_MAX : '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend  <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      sticky_q <= 1'b0;
      exp_q    <= '0;
      raddr_q  <= '0;
    end else begin
      rd_pend <= is_read;
      last_q  <= is_read && elem == E_LAST && addr_end;
      done_q  <= rd_pend && last_q;
      if (is_read) begin
        exp_q   <= bg ^ {DATA_W{pol_r}};
        raddr_q <= addr;
      end
      if (accept)       sticky_q <= 1'b0;
      else if (rd_fail) sticky_q <= 1'b1;
    end
  end

  // R3
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R4
  valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> rd_valid);
  // R4
  fail_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fail |-> rd_valid);
  // R5
  fail_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fail |=> fail_sticky);
  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_sticky && !start) |=> fail_sticky);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_we && !mem_re && !rd_valid));

endmodule

// File: tb/march_c_bist_tb_top.sv
module march_c_bist_tb_top;
  localparam int AW  = 4;
  localparam int DW  = 16;
  localparam int N   = 1 << AW;
  localparam int TOT = 10 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_we, mem_re, rd_valid, rd_fail, fail_sticky, done;

  int errors = 0;
  int checks = 0;

  logic [DW-1:0] mem [N];
  bit            f_en = 1'b0;
  bit            f_one = 1'b1;
  int            f_addr = 2;
  int            f_bit = 1;

  bit            r_we [TOT];
  bit            r_re [TOT];
  int            r_addr [TOT];
  logic [DW-1:0] r_wd [TOT];
  logic [DW-1:0] r_ex [TOT];

  always #4 clk = ~clk;

  march_c_bist #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_fail(rd_fail),
    .fail_addr(fail_addr), .fail_sticky(fail_sticky), .done(done)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) begin
      logic [DW-1:0] v;
      v = mem[mem_addr];
      if (f_en && int'(mem_addr) == f_addr) v[f_bit] = f_one;
      mem_rdata <= v;
    end
  end

  function automatic logic [DW-1:0] bg0(input int a);
    return (a % 2 == 1) ? 16'hAAAA : 16'h5555;
  endfunction

  task automatic put(inout int k, input bit we, input int a, input logic [DW-1:0] d);
    r_we[k] = we; r_re[k] = !we; r_addr[k] = a;
    r_wd[k] = d;  r_ex[k] = d;
    k++;
  endtask

  task automatic build_ref();
    int k = 0;
    for (int a = 0; a < N; a++) put(k, 1, a, bg0(a));
    for (int a = 0; a < N; a++) begin put(k, 0, a, bg0(a));  put(k, 1, a, ~bg0(a)); end
    for (int a = 0; a < N; a++) begin put(k, 0, a, ~bg0(a)); put(k, 1, a, bg0(a));  end
    for (int a = N-1; a >= 0; a--) begin put(k, 0, a, bg0(a));  put(k, 1, a, ~bg0(a)); end
    for (int a = N-1; a >= 0; a--) begin put(k, 0, a, ~bg0(a)); put(k, 1, a, bg0(a));  end
    for (int a = 0; a < N; a++) put(k, 0, a, bg0(a));
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!mem_we && !mem_re, "R9", "ops after reset", {mem_we, mem_re}, 0);
    chk(!done && !rd_valid && !fail_sticky, "R9", "status after reset",
        {done, rd_valid, fail_sticky}, 0);
  endtask

  // One full run checked op by op against the reference list.
  task automatic run_seq(input bit fen, input bit fone, input int exp_fails,
                         input int mid_at, input bit chain, input string tag);
    int fails = 0;
    int reads = 0;
    f_en = fen; f_one = fone;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i <= TOT + 1; i++) begin
      if (i > 0) @(negedge clk);
      if (i == mid_at) start = 1'b1;
      else if (i == mid_at + 1) start = 1'b0;
      if (i < TOT) begin
        // R1 R2 R3
        chk(mem_we == r_we[i] && mem_re == r_re[i] && int'(mem_addr) == r_addr[i] &&
            (!r_we[i] || mem_wdata == r_wd[i]), r_we[i] ? "R2" : "R1",
            {tag, " op"}, {mem_we, mem_re, 4'(mem_addr), mem_wdata},
            {r_we[i], r_re[i], 4'(r_addr[i]), r_wd[i]});
      end
      if (i > 0 && i <= TOT && r_re[i-1]) begin
        reads++;
        if (rd_fail) fails++;
        // R4
        chk(rd_valid && rd_fail == (mem_rdata != r_ex[i-1]) && int'(fail_addr) == r_addr[i-1],
            "R4", {tag, " read check"}, {rd_valid, rd_fail, 4'(fail_addr)},
            {1'b1, mem_rdata != r_ex[i-1], 4'(r_addr[i-1])});
      end else if (i <= TOT) begin
        chk(!rd_valid && !rd_fail, "R4", {tag, " no read"}, {rd_valid, rd_fail}, 0);
      end
      if (i == TOT) chk(!done, "R6", {tag, " done early"}, done, 0);
      if (i == TOT + 1) begin
        // R6 R5
        chk(done && !mem_we && !mem_re, "R6", {tag, " done cycle"}, {done, mem_we, mem_re}, 3'b100);
        chk(fail_sticky == (exp_fails > 0), "R5", {tag, " sticky"}, fail_sticky, exp_fails > 0);
      end
    end
    chk(fails == exp_fails, "R4", {tag, " fail count"}, fails, exp_fails);
    chk(reads == 5 * N, "R1", {tag, " read count"}, reads, 5 * N);
    if (chain) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R6", {tag, " done width"}, done, 0);
    if (chain) begin
      // R8
      chk(!fail_sticky && mem_we && mem_addr == '0, "R8", {tag, " restart at done"},
          {fail_sticky, mem_we, mem_addr}, {1'b0, 1'b1, 4'h0});
    end
  endtask

  task automatic wait_done();
    bit seen = 1'b0;
    for (int c = 0; c < 4 * TOT && !seen; c++) begin
      @(negedge clk);
      seen = done;
    end
    chk(seen, "R8", "chained run completes", seen, 1);
  endtask

  initial begin
    build_ref();
    for (int a = 0; a < N; a++) mem[a] = '0;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_seq(1'b0, 1'b1, 0, -1, 1'b0, "clean");
    run_seq(1'b1, 1'b1, 3, -1, 1'b0, "stuck1");
    run_seq(1'b1, 1'b0, 2, -1, 1'b0, "stuck0");
    // R7: start at op 100 (sticky already set) must change nothing
    run_seq(1'b1, 1'b1, 3, 100, 1'b0, "R7 midstart");
    run_seq(1'b1, 1'b1, 3, TOT, 1'b1, "R7 pending");
    f_en = 1'b0;
    wait_done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule